// File: doc/BRIEF.md
# Serial Converter Output Sequencer

This block produces the digital behaviour of a 12-bit sampling converter that reports through a three-wire serial port. An active-low select, a serial clock and a data line with a separate enable make up the port. The analog conversion is not modelled. A parallel word arrives with a valid strobe, and the block holds it. When the select falls, the held word is frozen as the result of the current conversion. The block then walks through its phases, one step on each falling serial clock edge. The data line first stays undriven while the converter samples. It then drives a low null bit, then sends the word most significant bit first. After that comes a tail, chosen by a parameter.

Both the select and the serial clock are asynchronous to the block's system clock. Each passes through a two-flop synchronizer and a fall detector. Only the synchronized edges move the state machine, so an output follows its serial clock edge by three system clock cycles.

The tail is picked by `TAIL_ZEROS`:
- **0:** the word is sent again least significant bit first, starting at B1 so that B0 is not repeated. The line is then released.
- **1:** the line sends zeros for as long as the select stays low.

States and transitions:
- **ST_IDLE:** the select is high, or a frame has not yet been started.
- **ST_SAMPLE:** entered on a synchronized select fall. It counts two serial clock falls, then moves to ST_NULL.
- **ST_NULL:** the next fall moves it to ST_MSB with the index at 11.
- **ST_MSB:** the index counts down. After index 0 it moves to ST_LSB with the index at 1 when `TAIL_ZEROS`=0, or to ST_ZERO when `TAIL_ZEROS`=1.
- **ST_LSB:** the index counts up. After index 11 it moves to ST_DONE.
- **ST_ZERO:** stays until the select rises.
- **ST_DONE:** stays until the select rises.

A high synchronized select sends every state to ST_IDLE. A synchronized select fall sends every state to ST_SAMPLE and takes priority over any serial clock event in the same cycle.

Top module: `ser_adc_seq`

## Requirements
- R1: While `rst_n` is low, and after its release with `csn` high, `sdo_oe` is 0 and `sdo` is 0.
- R2: Within 4 system clock cycles of `csn` going high, `sdo_oe` is 0. It stays 0 while `csn` is high, whatever `sclk` does.
- R3: After `csn` falls, `sdo_oe` stays 0 through the first falling `sclk` edge. The second falling edge sets `sdo_oe` to 1 with `sdo` at 0, which is the null bit.
- R4: Falling edges 3 to 14 after the `csn` fall put word bits B11 down to B0 on `sdo`, one bit per edge, with `sdo_oe` at 1.
- R5: With `TAIL_ZEROS`=0, falling edges 15 to 25 put B1 up to B11 on `sdo`. From edge 26 on, `sdo_oe` is 0 until `csn` goes high.
- R6: With `TAIL_ZEROS`=1, from falling edge 15 on, `sdo` is 0 with `sdo_oe` at 1 for as long as `csn` stays low.
- R7: The word sent in a frame is the last `sample_data` presented with `sample_valid`=1 before the `csn` fall. A valid strobe during the frame does not change that frame's bits, but it is used in the next frame.
- R8: Raising `csn` in the middle of a frame ends it. The next `csn` fall starts again from the sampling phase, and the sequence of R3 and R4 is repeated in full.
- R9: `sdo` and `sdo_oe` change only 3 system clock cycles after a falling `sclk` or a `csn` transition at the pins, and never otherwise.
- R10: `sdo` is 0 whenever `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn | input | 1 | Active-low chip select, asynchronous to `clk` |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| sample_data | input | WORD_W (12) | Parallel conversion result |
| sample_valid | input | 1 | Strobe that loads `sample_data` into the holding register |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for `sdo` (1 = driven, 0 = high impedance) |

## Verification
On every cycle, the checker confirms four things:
- the enable drops after a synchronized high select;
- a rising enable always shows a low null bit;
- the outputs hold still unless a synchronized edge occurred;
- the finished state is kept while the select stays low, and the data line is low whenever it is undriven.

Only the bench's scenarios can show the bit order of each phase against an independently computed sequence. The same goes for the choice of tail, the freezing of the word at the select fall while new samples arrive, and the clean restart after an aborted frame.

// File: rtl/ser_adc_seq_pkg.sv
package ser_adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SAMPLE = 3'd1,
        ST_NULL   = 3'd2,
        ST_MSB    = 3'd3,
        ST_LSB    = 3'd4,
        ST_ZERO   = 3'd5,
        ST_DONE   = 3'd6
    } seq_state_t;

    // serial clock falls spent in the sampling phase before the null bit
    localparam int SAMPLE_FALLS = 2;

endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic lvl_o
);

    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], async_i};
        end
    end

    assign lvl_o = pipe_q[STAGES-1];

endmodule

// File: rtl/ser_fall_det.sv
module ser_fall_det #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic fall_o
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= lvl_i;
        end
    end

    assign fall_o = prev_q & ~lvl_i;

endmodule

// File: rtl/ser_word_hold.sv
module ser_word_hold #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] sample_data,
    input  logic              sample_valid,
    input  logic              start_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] held_q;
    logic [WORD_W-1:0] frame_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (sample_valid) begin
            held_q <= sample_data;
        end
    end

    // the frame word is frozen at the start of a conversion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (start_i) begin
            frame_q <= held_q;
        end
    end

    assign word_o = frame_q;

endmodule

// File: rtl/ser_phase_fsm.sv
module ser_phase_fsm
    import ser_adc_seq_pkg::*;
#(
    parameter int WORD_W     = 12,
    parameter bit TAIL_ZEROS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_high,
    input  logic              cs_fall,
    input  logic              sclk_fall,
    input  logic [WORD_W-1:0] word_i,
    output seq_state_t        state_o,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int SMP_W = $clog2(SAMPLE_FALLS + 1);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WORD_W - 1);
    localparam logic [SMP_W-1:0] SMP_END = SMP_W'(SAMPLE_FALLS - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [SMP_W-1:0] smp_q, smp_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            smp_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            smp_q   <= smp_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        smp_d   = smp_q;
        if (cs_fall) begin
            state_d = ST_SAMPLE;
            idx_d   = '0;
            smp_d   = '0;
        end else if (cs_high) begin
            state_d = ST_IDLE;
            idx_d   = '0;
            smp_d   = '0;
        end else if (sclk_fall) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_SAMPLE: begin
                    if (smp_q == SMP_END) begin
                        state_d = ST_NULL;
                        smp_d   = '0;
                    end else begin
                        smp_d = smp_q + 1'b1;
                    end
                end
                ST_NULL: begin
                    state_d = ST_MSB;
                    idx_d   = IDX_TOP;
                end
                ST_MSB: begin
                    if (idx_q == '0) begin
                        if (TAIL_ZEROS) begin
                            state_d = ST_ZERO;
                        end else begin
                            state_d = ST_LSB;
                            idx_d   = IDX_W'(1);
                        end
                    end else begin
                        idx_d = idx_q - 1'b1;
                    end
                end
                ST_LSB: begin
                    if (idx_q == IDX_TOP) begin
                        state_d = ST_DONE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                ST_ZERO: begin
                    state_d = ST_ZERO;
                end
                ST_DONE: begin
                    state_d = ST_DONE;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sdo    = 1'b0;
        sdo_oe = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_SAMPLE, ST_DONE: begin
                sdo    = 1'b0;
                sdo_oe = 1'b0;
            end
            ST_NULL, ST_ZERO: begin
                sdo    = 1'b0;
                sdo_oe = 1'b1;
            end
            ST_MSB, ST_LSB: begin
                sdo    = word_i[idx_q];
                sdo_oe = 1'b1;
            end
            default: begin
                sdo    = 1'b0;
                sdo_oe = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/ser_adc_seq.sv
module ser_adc_seq
    import ser_adc_seq_pkg::*;
#(
    parameter int WORD_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter bit TAIL_ZEROS  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn,
    input  logic              sclk,
    input  logic [WORD_W-1:0] sample_data,
    input  logic              sample_valid,
    output logic              sdo,
    output logic              sdo_oe
);

    logic       cs_high;
    logic       cs_fall;
    logic       sclk_lvl;
    logic       sclk_fall;
    logic [WORD_W-1:0] frame_word;
    seq_state_t state;

    ser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) cs_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (csn),
        .lvl_o   (cs_high)
    );

    ser_fall_det #(.RST_VAL(1'b1)) cs_fall_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (cs_high),
        .fall_o (cs_fall)
    );

    ser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) sclk_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sclk),
        .lvl_o   (sclk_lvl)
    );

    ser_fall_det #(.RST_VAL(1'b0)) sclk_fall_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sclk_lvl),
        .fall_o (sclk_fall)
    );

    ser_word_hold #(.WORD_W(WORD_W)) hold_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_data  (sample_data),
        .sample_valid (sample_valid),
        .start_i      (cs_fall),
        .word_o       (frame_word)
    );

    ser_phase_fsm #(.WORD_W(WORD_W), .TAIL_ZEROS(TAIL_ZEROS)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_high   (cs_high),
        .cs_fall   (cs_fall),
        .sclk_fall (sclk_fall),
        .word_i    (frame_word),
        .state_o   (state),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

endmodule

// File: rtl/ser_adc_seq_chk.sv
module ser_adc_seq_chk
    import ser_adc_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_high,
    input logic       cs_fall,
    input logic       sclk_fall,
    input seq_state_t state,
    input logic       sdo,
    input logic       sdo_oe
);

    // R2
    cs_high_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_high |=> !sdo_oe);

    // R3
    null_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !sdo);

    // R9
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !cs_fall && !cs_high) |=> ($stable(sdo) && $stable(sdo_oe)));

    // R5
    done_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !cs_high && !cs_fall) |=> (state == ST_DONE && !sdo_oe));

    // R10
    idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

endmodule

bind ser_adc_seq ser_adc_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_high   (cs_high),
    .cs_fall   (cs_fall),
    .sclk_fall (sclk_fall),
    .state     (state),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
);

// File: tb/ser_adc_seq_tb_top.sv
`timescale 1ns/1ps
module ser_adc_seq_tb_top;

    localparam int WORD_W = 12;
    localparam int HALF   = 8;
    localparam int NVEC   = 6;
    localparam logic [WORD_W-1:0] VEC [NVEC] = '{
        12'hA5C, 12'h000, 12'hFFF, 12'h801, 12'h123, 12'h7FE
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1;
    logic sclk = 1'b0;
    logic [WORD_W-1:0] sample_data = '0;
    logic sample_valid = 1'b0;
    logic sdo_a, oe_a, sdo_z, oe_z;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ser_adc_seq #(.WORD_W(WORD_W), .TAIL_ZEROS(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk),
        .sample_data(sample_data), .sample_valid(sample_valid),
        .sdo(sdo_a), .sdo_oe(oe_a)
    );

    ser_adc_seq #(.WORD_W(WORD_W), .TAIL_ZEROS(1'b1)) dut_z (
        .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk),
        .sample_data(sample_data), .sample_valid(sample_valid),
        .sdo(sdo_z), .sdo_oe(oe_z)
    );

    task automatic chk(input string req, input logic got_oe, input logic got_sdo,
                       input logic exp_oe, input logic exp_sdo);
        n_chk++;
        if (got_oe !== exp_oe || got_sdo !== exp_sdo) begin
            n_fail++;
            $display("FAIL %s: oe/sdo actual %b/%b expected %b/%b at %0t",
                     req, got_oe, got_sdo, exp_oe, exp_sdo, $time);
        end
    endtask

    // expected output after falling edge n of a frame (n = 0 before any)
    function automatic logic [1:0] expect_out(input int n, input logic [WORD_W-1:0] w,
                                              input bit zeros);
        if (n < 2) return 2'b00;                        // R3 sampling
        if (n == 2) return 2'b10;                       // R3 null bit
        if (n <= 14) return {1'b1, w[14-n]};            // R4
        if (zeros) return 2'b10;                        // R6
        if (n <= 25) return {1'b1, w[n-14]};            // R5
        return 2'b00;                                   // R5 released
    endfunction

    function automatic string tag_for(input int n, input bit zeros);
        if (n <= 2) return "R3";
        if (n <= 14) return "R4";
        return zeros ? "R6" : "R5";
    endfunction

    task automatic wait_clk(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic load_sample(input logic [WORD_W-1:0] w);
        @(posedge clk); #1;
        sample_data  = w;
        sample_valid = 1'b1;
        @(posedge clk); #1;
        sample_valid = 1'b0;
    endtask

    task automatic sclk_pulse();
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
        wait_clk(HALF);
    endtask

    // frame: nfalls edges, expected word w; at edge mid_at a new sample is loaded
    task automatic run_frame(input logic [WORD_W-1:0] w, input int nfalls,
                             input int mid_at, input logic [WORD_W-1:0] mid_w,
                             input string extra);
        logic [1:0] ea, ez;
        csn = 1'b0;
        wait_clk(HALF);
        @(negedge clk);
        chk({"R3 ", extra}, oe_a, sdo_a, 1'b0, 1'b0);
        for (int n = 1; n <= nfalls; n++) begin
            if (n == mid_at) load_sample(mid_w);
            sclk_pulse();
            @(negedge clk);
            ea = expect_out(n, w, 1'b0);
            ez = expect_out(n, w, 1'b1);
            chk({tag_for(n, 1'b0), " ", extra}, oe_a, sdo_a, ea[1], ea[0]);
            chk({tag_for(n, 1'b1), " ", extra}, oe_z, sdo_z, ez[1], ez[0]);
        end
    endtask

    task automatic end_frame();
        csn = 1'b1;
        wait_clk(HALF);
        @(negedge clk);
        chk("R2 release", oe_a, sdo_a, 1'b0, 1'b0);
        chk("R2 release", oe_z, sdo_z, 1'b0, 1'b0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_clk(4);
        @(negedge clk);
        chk("R1 in reset", oe_a, sdo_a, 1'b0, 1'b0);
        chk("R1 in reset", oe_z, sdo_z, 1'b0, 1'b0);
        rst_n = 1'b1;
        wait_clk(6);
        @(negedge clk);
        chk("R1 after reset", oe_a, sdo_a, 1'b0, 1'b0);

        // R2: serial clocks with select high do nothing
        for (int k = 0; k < 3; k++) begin
            sclk_pulse();
            @(negedge clk);
            chk("R2 sclk while high", oe_a, sdo_a, 1'b0, 1'b0);
            chk("R2 sclk while high", oe_z, sdo_z, 1'b0, 1'b0);
        end

        // vector table: R3 R4 R5 R6 with several words
        for (int v = 0; v < NVEC; v++) begin
            load_sample(VEC[v]);
            run_frame(VEC[v], 28, 0, '0, "table");
            end_frame();
        end

        // R8: abort after 6 edges, then a full fresh frame
        load_sample(12'h3C6);
        run_frame(12'h3C6, 6, 0, '0, "R8 abort");
        end_frame();
        run_frame(12'h3C6, 16, 0, '0, "R8 restart");
        end_frame();

        // R7: a new sample mid-frame leaves this frame alone, is used in the next
        load_sample(12'hB4D);
        run_frame(12'hB4D, 26, 5, 12'h52A, "R7 mid load");
        end_frame();
        run_frame(12'h52A, 14, 0, '0, "R7 next frame");
        end_frame();

        // R9: outputs are still 2 cycles after a fall and updated by the 4th cycle
        csn = 1'b0;
        wait_clk(HALF);
        sclk_pulse();
        sclk = 1'b1;
        wait_clk(HALF);
        @(posedge clk); #1;
        sclk = 1'b0;
        wait_clk(1);
        @(negedge clk);
        chk("R9 early", oe_a, sdo_a, 1'b0, 1'b0);
        wait_clk(3);
        @(negedge clk);
        chk("R9 late", oe_a, sdo_a, 1'b1, 1'b0);
        end_frame();

        // R10: undriven line reads low while idle
        @(negedge clk);
        chk("R10 idle", oe_z, sdo_z, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule